// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Pinned Entries

This block caches page-to-frame translations. A lookup compares the page number it is given with every stored tag at once. On a match it returns the frame number in the same cycle, with no register in the path. On no match it raises a miss. The external table walker then fetches the translation and writes the page/frame pair back through the fill port.

Entries can be pinned (wired). A pinned entry is never picked as a replacement victim, and the flush that is used on a context switch does not remove it. A fill chooses its slot in this order:

1. An entry that already holds the same page is updated in place.
2. Otherwise the lowest free entry is used.
3. Otherwise a round-robin pointer picks the next unpinned entry.

If every entry is pinned and none matches, the fill is refused. Two saturating counters record how many lookups were made and how many of them hit, so software can work out the hit ratio.

Top module: `xlat_cache`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, and both counters read zero.
- R2: A lookup (`lk_valid`=1) whose page matches a valid entry asserts `lk_hit` combinationally in the same cycle and drives that entry's frame number on `lk_frame`.
- R3: A lookup with no matching valid entry asserts `lk_miss` and drives `lk_frame` to zero. With `lk_valid`=0, neither `lk_hit` nor `lk_miss` is asserted.
- R4: A fill whose page has no valid entry is written into the lowest-indexed invalid entry, if one exists. It becomes visible to lookups in the cycle after the fill.
- R5: A fill whose page already has a valid entry overwrites that entry's frame and pinned flag. No second entry is created, and no other entry changes.
- R6: When all entries are valid and none matches, the victim is the first unpinned entry found scanning upward (with wrap) from the round-robin pointer. The pointer starts at entry 0 and moves to the entry after each victim.
- R7: A pinned entry (filled with `fill_wired`=1) is never chosen as a victim. It keeps its translation until a fill to the same page updates it.
- R8: `flush` invalidates every unpinned entry at the next clock edge. Pinned entries stay valid and keep their translations.
- R9: A fill that finds no matching entry while every entry is valid and pinned asserts `fill_err` in the same cycle and changes no entry.
- R10: `lookup_cnt` counts the cycles with `lk_valid`=1, and `hit_cnt` counts the cycles with `lk_hit`=1. Each counter updates at the following edge and saturates at its maximum value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| lk_valid | input | 1 | Lookup request in this cycle |
| lk_page | input | PAGE_W | Page number to translate |
| lk_hit | output | 1 | Lookup found a valid matching entry |
| lk_miss | output | 1 | Lookup found no valid matching entry |
| lk_frame | output | FRAME_W | Frame number of the matching entry, zero otherwise |
| fill_valid | input | 1 | Insert or update a translation at the next edge |
| fill_page | input | PAGE_W | Page number of the fill |
| fill_frame | input | FRAME_W | Frame number of the fill |
| fill_wired | input | 1 | Pin the filled entry |
| fill_err | output | 1 | Fill refused: no match and every entry pinned |
| flush | input | 1 | Invalidate all unpinned entries |
| lookup_cnt | output | CNT_W | Saturating count of lookups |
| hit_cnt | output | CNT_W | Saturating count of hits |

## Verification
The assertions check these rules on every cycle:
- `lk_hit` and `fill_err` only appear together with their requests.
- The hit count never exceeds the lookup count.
- The lookup counter steps by exactly one per lookup below saturation.
- Every pinned entry is still valid after a flush.

The bench scenarios are needed for the rest. Only they can show which slot a fill lands in, the order in which round-robin victims are taken when some entries are pinned, in-place update without duplication, and the refused fill leaving every translation intact. Each of these is observed through later lookups.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [2:0] {
    FILL_NONE,
    FILL_UPDATE,
    FILL_FREE,
    FILL_EVICT,
    FILL_REJECT
  } fill_act_e;
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 12,
  parameter int FRAME_W = 10
) (
  input  logic [PAGE_W-1:0]  page,
  input  logic [ENTRIES-1:0] valid,
  input  logic [PAGE_W-1:0]  tags   [ENTRIES],
  input  logic [FRAME_W-1:0] frames [ENTRIES],
  output logic [ENTRIES-1:0] match_vec,
  output logic               any_match,
  output logic [FRAME_W-1:0] frame
);
  // parallel tag compare, one comparator per entry
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = valid[g] && (tags[g] == page);
  end

  assign any_match = |match_vec;

  // tags are unique, so an OR of masked frames selects the single hit
  always_comb begin
    frame = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_vec[i]) frame = frame | frames[i];
    end
  end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic               req,
  input  logic [ENTRIES-1:0] valid,
  input  logic [ENTRIES-1:0] wired,
  input  logic [ENTRIES-1:0] match_vec,
  input  logic [IDX_W-1:0]   rr_ptr,
  output fill_act_e          act,
  output logic [IDX_W-1:0]   idx
);
  logic             m_found, f_found, r_found;
  logic [IDX_W-1:0] m_idx, f_idx, r_idx;

  always_comb begin
    m_found = 1'b0;
    f_found = 1'b0;
    m_idx   = '0;
    f_idx   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!m_found && match_vec[i]) begin
        m_found = 1'b1;
        m_idx   = IDX_W'(i);
      end
      if (!f_found && !valid[i]) begin
        f_found = 1'b1;
        f_idx   = IDX_W'(i);
      end
    end
  end

  // circular scan from the pointer for the first unpinned entry
  always_comb begin
    r_found = 1'b0;
    r_idx   = '0;
    for (int k = 0; k < ENTRIES; k++) begin
      int j;
      j = int'(rr_ptr) + k;
      if (j >= ENTRIES) j = j - ENTRIES;
      if (!r_found && !wired[j]) begin
        r_found = 1'b1;
        r_idx   = IDX_W'(j);
      end
    end
  end

  always_comb begin
    act = FILL_NONE;
    idx = '0;
    if (req) begin
      if (m_found) begin
        act = FILL_UPDATE;
        idx = m_idx;
      end else if (f_found) begin
        act = FILL_FREE;
        idx = f_idx;
      end else if (r_found) begin
        act = FILL_EVICT;
        idx = r_idx;
      end else begin
        act = FILL_REJECT;
      end
    end
  end
endmodule

// File: rtl/xlat_stats.sv
module xlat_stats #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_lookup,
  input  logic             inc_hit,
  output logic [CNT_W-1:0] lookup_cnt,
  output logic [CNT_W-1:0] hit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] lk_q, lk_d, ht_q, ht_d;
  logic             lk_en, ht_en;

  always_comb begin
    lk_en = inc_lookup && (lk_q != CNT_MAX);
    ht_en = inc_hit && (ht_q != CNT_MAX);
    lk_d  = lk_q + CNT_W'(1);
    ht_d  = ht_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lk_q <= '0;
      ht_q <= '0;
    end else begin
      if (lk_en) lk_q <= lk_d;
      if (ht_en) ht_q <= ht_d;
    end
  end

  assign lookup_cnt = lk_q;
  assign hit_cnt    = ht_q;
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int PAGE_W  = 12,
  parameter int FRAME_W = 10,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [PAGE_W-1:0]  lk_page,
  output logic               lk_hit,
  output logic               lk_miss,
  output logic [FRAME_W-1:0] lk_frame,
  input  logic               fill_valid,
  input  logic [PAGE_W-1:0]  fill_page,
  input  logic [FRAME_W-1:0] fill_frame,
  input  logic               fill_wired,
  output logic               fill_err,
  input  logic               flush,
  output logic [CNT_W-1:0]   lookup_cnt,
  output logic [CNT_W-1:0]   hit_cnt
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // reset: asynchronous assertion, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [ENTRIES-1:0] valid_q, valid_d, wired_q, wired_d;
  logic [PAGE_W-1:0]  tag_q   [ENTRIES];
  logic [FRAME_W-1:0] frame_q [ENTRIES];
  logic [IDX_W-1:0]   rr_q, rr_d;

  logic [ENTRIES-1:0] lk_vec, fill_vec;
  logic               lk_any, fill_any;
  logic [FRAME_W-1:0] lk_frm, fill_frm_unused;
  fill_act_e          act;
  logic [IDX_W-1:0]   act_idx;
  logic               wr_en;

  xlat_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_lk_match (
    .page(lk_page), .valid(valid_q), .tags(tag_q), .frames(frame_q),
    .match_vec(lk_vec), .any_match(lk_any), .frame(lk_frm)
  );

  xlat_match #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_fill_match (
    .page(fill_page), .valid(valid_q), .tags(tag_q), .frames(frame_q),
    .match_vec(fill_vec), .any_match(fill_any), .frame(fill_frm_unused)
  );

  xlat_victim #(.ENTRIES(ENTRIES)) u_victim (
    .req(fill_valid), .valid(valid_q), .wired(wired_q), .match_vec(fill_vec),
    .rr_ptr(rr_q), .act(act), .idx(act_idx)
  );

  assign lk_hit   = lk_valid && lk_any;
  assign lk_miss  = lk_valid && !lk_any;
  assign lk_frame = lk_hit ? lk_frm : '0;
  assign fill_err = (act == FILL_REJECT);
  assign wr_en    = (act == FILL_UPDATE) || (act == FILL_FREE) || (act == FILL_EVICT);

  // flag state next value
  always_comb begin
    valid_d = valid_q;
    wired_d = wired_q;
    if (flush) valid_d = valid_q & wired_q;
    if (wr_en) begin
      valid_d[act_idx] = 1'b1;
      wired_d[act_idx] = fill_wired;
    end
    wired_d = wired_d & valid_d;
  end

  always_comb begin
    rr_d = rr_q;
    if (act == FILL_EVICT) begin
      if (int'(act_idx) == ENTRIES - 1) rr_d = '0;
      else                              rr_d = act_idx + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q <= '0;
      wired_q <= '0;
      rr_q    <= '0;
    end else begin
      valid_q <= valid_d;
      wired_q <= wired_d;
      rr_q    <= rr_d;
    end
  end

  // payload storage: written only under the fill enable, no reset needed
  for (genvar g = 0; g < ENTRIES; g++) begin : g_store
    logic we;
    assign we = wr_en && (int'(act_idx) == g);
    always_ff @(posedge clk) begin
      if (we) begin
        tag_q[g]   <= fill_page;
        frame_q[g] <= fill_frame;
      end
    end
  end

  xlat_stats #(.CNT_W(CNT_W)) u_stats (
    .clk(clk), .rst_n(rst_sync_n), .inc_lookup(lk_valid), .inc_hit(lk_hit),
    .lookup_cnt(lookup_cnt), .hit_cnt(hit_cnt)
  );
endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int ENTRIES = 8,
  parameter int CNT_W   = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic               lk_hit,
  input logic               fill_valid,
  input logic               fill_err,
  input logic               flush,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] wired_q,
  input logic [CNT_W-1:0]   lookup_cnt,
  input logic [CNT_W-1:0]   hit_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R2
  hit_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_valid);

  // R9
  err_needs_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_err |-> fill_valid);

  // R10
  hit_le_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_cnt <= lookup_cnt);

  // R10
  lookup_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lookup_cnt != CNT_MAX) |=> (lookup_cnt == $past(lookup_cnt) + CNT_W'(1)));

  // R8
  pinned_survive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> ((valid_q & $past(wired_q)) == $past(wired_q)));
endmodule

bind xlat_cache xlat_cache_chk #(.ENTRIES(ENTRIES), .CNT_W(CNT_W)) u_xlat_chk (
  .clk(clk), .rst_n(rst_sync_n), .lk_valid(lk_valid), .lk_hit(lk_hit),
  .fill_valid(fill_valid), .fill_err(fill_err), .flush(flush),
  .valid_q(valid_q), .wired_q(wired_q), .lookup_cnt(lookup_cnt), .hit_cnt(hit_cnt)
);

// File: tb/test_xlat_cache.sv
`timescale 1ns/1ps
module test_xlat_cache;
  localparam int ENTRIES = 4;
  localparam int PAGE_W  = 8;
  localparam int FRAME_W = 6;
  localparam int CNT_W   = 8;
  localparam int CMAX    = 255;

  logic clk = 1'b0;
  logic rst_n;
  logic lk_valid, lk_hit, lk_miss;
  logic [PAGE_W-1:0]  lk_page, fill_page;
  logic [FRAME_W-1:0] lk_frame, fill_frame;
  logic fill_valid, fill_wired, fill_err, flush;
  logic [CNT_W-1:0] lookup_cnt, hit_cnt;

  int n_chk = 0, n_bad = 0;
  int exp_lk = 0, exp_hit = 0;
  bit done = 0;

  always #2 clk = ~clk;

  xlat_cache #(.ENTRIES(ENTRIES), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) i_xlat_cache (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_page(lk_page),
    .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_frame(lk_frame),
    .fill_valid(fill_valid), .fill_page(fill_page), .fill_frame(fill_frame),
    .fill_wired(fill_wired), .fill_err(fill_err), .flush(flush),
    .lookup_cnt(lookup_cnt), .hit_cnt(hit_cnt)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; lk_valid = 0; lk_page = '0; fill_valid = 0; fill_page = '0;
    fill_frame = '0; fill_wired = 0; flush = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    exp_lk = 0; exp_hit = 0;
  endtask

  task automatic lookup(int page, bit hit, int frame, string req);
    @(negedge clk);
    lk_valid = 1; lk_page = PAGE_W'(page);
    #1;
    chk(req, $sformatf("hit page %0h", page), lk_hit, hit);
    chk(req, $sformatf("miss page %0h", page), lk_miss, !hit);
    chk(req, $sformatf("frame page %0h", page), lk_frame, hit ? frame : 0);
    @(posedge clk); #1 lk_valid = 0;
    if (exp_lk < CMAX) exp_lk++;
    if (hit && exp_hit < CMAX) exp_hit++;
  endtask

  task automatic fill(int page, int frame, bit wired, bit err, string req);
    @(negedge clk);
    fill_valid = 1; fill_page = PAGE_W'(page); fill_frame = FRAME_W'(frame); fill_wired = wired;
    #1 chk(req, $sformatf("fill_err page %0h", page), fill_err, err);
    @(posedge clk); #1 fill_valid = 0; fill_wired = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1 flush = 0;
  endtask

  task automatic check_counts(string req);
    @(negedge clk);
    chk(req, "lookup_cnt", lookup_cnt, exp_lk);
    chk(req, "hit_cnt", hit_cnt, exp_hit);
  endtask

  task automatic t_reset();
    do_reset();
    check_counts("R1");
    lookup(8'h10, 0, 0, "R1");
    @(negedge clk);
    chk("R3", "idle hit", lk_hit, 0);
    chk("R3", "idle miss", lk_miss, 0);
  endtask

  task automatic t_fill_free();
    for (int i = 0; i < 4; i++) fill(8'h10 + i, 1 + i, 0, 0, "R4");
    for (int i = 0; i < 4; i++) lookup(8'h10 + i, 1, 1 + i, "R4");
    lookup(8'h14, 0, 0, "R3");
  endtask

  task automatic t_update();
    fill(8'h11, 9, 0, 0, "R5");
    lookup(8'h11, 1, 9, "R5");
    lookup(8'h10, 1, 1, "R5");
    lookup(8'h12, 1, 3, "R5");
    lookup(8'h13, 1, 4, "R5");
  endtask

  task automatic t_round_robin();
    fill(8'h20, 5, 0, 0, "R6");   // entry 0
    fill(8'h21, 6, 0, 0, "R6");   // entry 1
    lookup(8'h10, 0, 0, "R6");
    lookup(8'h11, 0, 0, "R6");
    lookup(8'h12, 1, 3, "R6");
    lookup(8'h20, 1, 5, "R6");
    lookup(8'h21, 1, 6, "R6");
  endtask

  task automatic t_wired();
    do_flush();                   // nothing pinned yet: all gone, pointer at 2
    lookup(8'h20, 0, 0, "R8");
    fill(8'h30, 10, 1, 0, "R7");  // entry 0 pinned
    fill(8'h31, 11, 1, 0, "R7");  // entry 1 pinned
    fill(8'h32, 12, 0, 0, "R7");  // entry 2
    fill(8'h33, 13, 0, 0, "R7");  // entry 3
    fill(8'h40, 14, 0, 0, "R6");  // evicts entry 2
    fill(8'h41, 15, 0, 0, "R6");  // evicts entry 3
    fill(8'h42, 16, 0, 0, "R7");  // pointer 0: skips 0,1 -> entry 2
    lookup(8'h30, 1, 10, "R7");
    lookup(8'h31, 1, 11, "R7");
    lookup(8'h40, 0, 0, "R7");
    lookup(8'h41, 1, 15, "R7");
    lookup(8'h42, 1, 16, "R7");
  endtask

  task automatic t_flush();
    do_flush();
    lookup(8'h30, 1, 10, "R8");
    lookup(8'h31, 1, 11, "R8");
    lookup(8'h41, 0, 0, "R8");
    lookup(8'h42, 0, 0, "R8");
  endtask

  task automatic t_all_wired();
    fill(8'h50, 20, 1, 0, "R9");
    fill(8'h51, 21, 1, 0, "R9");
    fill(8'h60, 22, 0, 1, "R9");
    lookup(8'h60, 0, 0, "R9");
    lookup(8'h30, 1, 10, "R9");
    lookup(8'h31, 1, 11, "R9");
    lookup(8'h50, 1, 20, "R9");
    lookup(8'h51, 1, 21, "R9");
    fill(8'h50, 30, 1, 0, "R5");
    lookup(8'h50, 1, 30, "R5");
    check_counts("R10");
  endtask

  task automatic t_saturate();
    do_reset();
    fill(8'h01, 7, 0, 0, "R10");
    for (int i = 0; i < 260; i++) lookup(8'h01, 1, 7, "R10");
    check_counts("R10");
    chk("R10", "lookup saturated", lookup_cnt, CMAX);
  endtask

  initial begin
    t_reset();
    t_fill_free();
    t_update();
    t_round_robin();
    t_wired();
    t_flush();
    t_all_wired();
    t_saturate();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule